// File: doc/BRIEF.md
# Random Value Generator with Stalling Read

This block is a memory-mapped source of 16-bit random numbers on a 32-bit bus. Each transfer uses a select/ready handshake. A pseudo-random shift register supplies the entropy. A fixed-length generation window decides when a fresh value is latched and flagged as valid. Software sets up the block through a 16-bit configuration word that holds a power-down control. It polls a status word for the valid flag and reads values from a value word.

A read of the value word that arrives before a value is valid holds the bus: ready stays low until generation finishes. The read then completes with the new value. That read clears the valid flag and starts the next window. While the block is powered down, the shift register and the window counter are frozen and no value is produced. The valid flag reads as 0, and a value read returns 0 at once so that the bus cannot stall forever.

Bus protocol: the master raises `bus_sel` and holds `bus_write`, `bus_addr` and `bus_wdata` stable until the cycle in which `bus_ready` is 1. The transfer takes effect at the rising clock edge of that cycle. `bus_rdata` is valid in that same cycle.

Top module: `rng_periph`

## Requirements
- R1: After synchronous reset the configuration word is 0, the valid flag is 0, the shift register holds SEED, and a generation window starts at once.
- R2: The configuration word at byte offset 0x00 stores `bus_wdata[15:0]` on a write. A read returns those 16 bits, and bits 31:16 read as 0.
- R3: Configuration bit 2 is the power-down control (1 = off). While it is 1, the shift register and the window counter do not advance, and the counter is cleared. Clearing the bit restarts a full window from the frozen register state.
- R4: The status word at byte offset 0x04 returns the valid flag in bit 0 and 0 in all other bits. It reads 0 whenever power-down is 1.
- R5: The shift register is a 32-bit Galois right-shifting LFSR with feedback mask 0x80200003 (polynomial x^32+x^22+x^2+x+1). It steps once per powered-up cycle. GEN_CYCLES powered-up edges after a window starts, the valid flag rises. The value latched is bits 15:0 of the register state (bits 31:16 when SAMPLE_HIGH=1), taken before that edge's step.
- R6: A read of the value word at byte offset 0x08 while the value is valid completes in the same cycle. It returns the value in bits 15:0 with 0 above, clears the valid flag and starts a new window.
- R7: A value read while powered up and not valid keeps `bus_ready` low. It completes in the first cycle in which the flag is valid.
- R8: A value read while power-down is 1 completes at once and returns 0.
- R9: Writes to 0x04, to 0x08 and to unmapped offsets complete at once and change nothing.
- R10: Reads of unmapped offsets, including misaligned ones, return 0. Reads of the configuration and status words always complete at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Transfer request, held until ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid while ready is 1 |
| bus_ready | output | 1 | Transfer completes at the coming edge |

## Verification
The bench keeps GEN_CYCLES at its default of 32, so each stalled read waits the full stated window. It sets SAMPLE_HIGH to 1, which puts the upper-half sampling variant under test. Its cycle-accurate reference of the LFSR and the window counter makes every returned value exact. This exposes a frozen register that keeps stepping, an off-by-one window length and a wrong sampled half. Reads stalled from reset, power-down toggled while a value is valid, and writes to read-only and unmapped offsets are all reached with these settings.

// File: rtl/rng_pkg.sv
// Package: register offsets and decode type shared by the generator.
// Assumes byte addressing with 32-bit aligned words.
package rng_pkg;
    localparam int unsigned OFF_CFG  = 32'h00;
    localparam int unsigned OFF_STAT = 32'h04;
    localparam int unsigned OFF_VAL  = 32'h08;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_CFG  = 2'd1,
        HIT_STAT = 2'd2,
        HIT_VAL  = 2'd3
    } reg_hit_e;
endpackage

// File: rtl/rng_lfsr.sv
// Galois right-shifting LFSR that steps only when enabled.
// Assumes MASK describes a maximal-length polynomial and SEED is non-zero.
module rng_lfsr #(
    parameter int W = 32,
    parameter logic [W-1:0] MASK = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'hACE1_0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] state
);
    logic [W-1:0] state_q;

    // Purpose: advance the register one step per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (en)
            state_q <= (state_q >> 1) ^ (state_q[0] ? MASK : '0);
    end

    assign state = state_q;

    assert_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/rng_gen_ctrl.sv
// Generation window counter, valid flag and value latch.
// Assumes GEN_CYCLES >= 2 and take only asserted while the flag is valid.
module rng_gen_ctrl #(
    parameter int GEN_CYCLES  = 32,
    parameter int LFSR_W      = 32,
    parameter int VAL_W       = 16,
    parameter bit SAMPLE_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dis,
    input  logic              take,
    input  logic [LFSR_W-1:0] lfsr_state,
    output logic              rdy_q,
    output logic [VAL_W-1:0]  val_q
);
    localparam int CNT_W = (GEN_CYCLES > 1) ? $clog2(GEN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GEN_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [VAL_W-1:0] sample;

    // Pick the half of the register that becomes the value.
    generate
        if (SAMPLE_HIGH) begin : g_hi
            logic unused_lo;
            assign sample    = lfsr_state[LFSR_W-1 -: VAL_W];
            assign unused_lo = ^lfsr_state[LFSR_W-VAL_W-1:0];
        end else begin : g_lo
            logic unused_hi;
            assign sample    = lfsr_state[VAL_W-1:0];
            assign unused_hi = ^lfsr_state[LFSR_W-1:VAL_W];
        end
    endgenerate

    // Purpose: run the window, latch the value, clear on take or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
            val_q <= '0;
        end else if (dis) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else if (take) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else if (!rdy_q) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
                rdy_q <= 1'b1;
                val_q <= sample;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_off_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis) |-> !rdy_q);
    assert_take_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !rdy_q);
    assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> $past(cnt_q) == CNT_LAST);
    assert_value_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q && $past(rdy_q) |-> $stable(val_q));
endmodule

// File: rtl/rng_bus_if.sv
// Bus decode, configuration register, read mux and ready generation.
// Assumes the master holds the request stable until ready.
module rng_bus_if
    import rng_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CFG_W   = 16,
    parameter int VAL_W   = 16,
    parameter int DIS_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic              rdy_q,
    input  logic [VAL_W-1:0]  val_q,
    output logic              dis,
    output logic              take
);
    reg_hit_e         hit;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_wr;
    logic             val_rd;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_W];

    // Purpose: map the byte offset to a register.
    always_comb begin
        if (bus_addr == ADDR_W'(OFF_CFG))       hit = HIT_CFG;
        else if (bus_addr == ADDR_W'(OFF_STAT)) hit = HIT_STAT;
        else if (bus_addr == ADDR_W'(OFF_VAL))  hit = HIT_VAL;
        else                                    hit = HIT_NONE;
    end

    assign cfg_wr = bus_sel & bus_write & (hit == HIT_CFG);
    assign val_rd = bus_sel & ~bus_write & (hit == HIT_VAL);

    // Purpose: hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= bus_wdata[CFG_W-1:0];
    end

    assign dis       = cfg_q[DIS_BIT];
    assign bus_ready = bus_sel & (~val_rd | rdy_q | dis);
    assign take      = val_rd & rdy_q & ~dis;

    // Purpose: select read data for the addressed word.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_write) begin
            unique case (hit)
                HIT_CFG:  bus_rdata = DATA_W'(cfg_q);
                HIT_STAT: bus_rdata = DATA_W'(rdy_q & ~dis);
                HIT_VAL:  bus_rdata = dis ? '0 : DATA_W'(val_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assert_cfg_only_by_cfg_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !(bus_write && hit == HIT_CFG) |=> $stable(cfg_q));
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_write && hit == HIT_NONE |-> bus_ready && bus_rdata == '0);
    assert_off_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        val_rd && dis |-> bus_ready && bus_rdata == '0);
endmodule

// File: rtl/rng_periph.sv
// Top: memory-mapped 16-bit random value source with stalling value read.
// Assumes a single bus master; power-down is a clock enable on the generator.
module rng_periph #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CFG_W       = 16,
    parameter int VAL_W       = 16,
    parameter int DIS_BIT     = 2,
    parameter int LFSR_W      = 32,
    parameter int GEN_CYCLES  = 32,
    parameter bit SAMPLE_HIGH = 1'b0,
    parameter logic [LFSR_W-1:0] LFSR_MASK = 32'h8020_0003,
    parameter logic [LFSR_W-1:0] SEED      = 32'hACE1_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready
);
    logic              dis;
    logic              take;
    logic              rdy_q;
    logic [VAL_W-1:0]  val_q;
    logic [LFSR_W-1:0] lfsr_state;

    rng_bus_if #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W),
        .VAL_W(VAL_W), .DIS_BIT(DIS_BIT)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .rdy_q(rdy_q), .val_q(val_q), .dis(dis), .take(take)
    );

    rng_lfsr #(.W(LFSR_W), .MASK(LFSR_MASK), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .en(~dis), .state(lfsr_state)
    );

    rng_gen_ctrl #(
        .GEN_CYCLES(GEN_CYCLES), .LFSR_W(LFSR_W), .VAL_W(VAL_W),
        .SAMPLE_HIGH(SAMPLE_HIGH)
    ) u_gen (
        .clk(clk), .rst_n(rst_n), .dis(dis), .take(take),
        .lfsr_state(lfsr_state), .rdy_q(rdy_q), .val_q(val_q)
    );

    assert_frozen_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis) |-> $stable(lfsr_state));
    assert_stall_until_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_write && bus_addr == ADDR_W'(rng_pkg::OFF_VAL) && !rdy_q && !dis
        |-> !bus_ready);
endmodule

// File: tb/test_rng_periph.sv
// Scoreboard bench: driver queues transfers, monitor compares at completion
// against a reference model built from the requirements.
module test_rng_periph;
    localparam int  GEN = 32;
    localparam bit  SH  = 1'b1;
    localparam logic [31:0] MASK = 32'h8020_0003;
    localparam logic [31:0] SEED = 32'hACE1_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdy;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    typedef struct { logic wr; logic [7:0] addr; string tag; } item_t;
    item_t sb_q[$];
    event  done_ev;

    // reference state
    logic [15:0] ref_cfg;
    logic [31:0] ref_lfsr;
    int          ref_cnt;
    logic        ref_rdy;
    logic [15:0] ref_val;

    always #4 clk = ~clk;

    rng_periph #(.GEN_CYCLES(GEN), .SAMPLE_HIGH(SH)) i_rng_periph (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_write(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(rdy)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model from R1, R3, R5, R6
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_cfg <= '0; ref_lfsr <= SEED; ref_cnt <= 0;
            ref_rdy <= 1'b0; ref_val <= '0;
        end else begin
            if (sel && wr && addr == 8'h00) ref_cfg <= wdata[15:0];
            if (ref_cfg[2]) begin
                ref_cnt <= 0; ref_rdy <= 1'b0;
            end else begin
                ref_lfsr <= (ref_lfsr >> 1) ^ (ref_lfsr[0] ? MASK : 32'h0);
                if (sel && !wr && addr == 8'h08 && ref_rdy) begin
                    ref_rdy <= 1'b0; ref_cnt <= 0;
                end else if (!ref_rdy) begin
                    if (ref_cnt == GEN - 1) begin
                        ref_rdy <= 1'b1; ref_cnt <= 0;
                        ref_val <= SH ? ref_lfsr[31:16] : ref_lfsr[15:0];
                    end else begin
                        ref_cnt <= ref_cnt + 1;
                    end
                end
            end
        end
    end

    // monitor: check ready every requested cycle, compare data at completion
    always @(negedge clk) begin
        #2;
        if (rst_n && sel) begin
            logic  is_val, exp_rdy;
            logic [31:0] exp_d;
            string rtag;
            is_val  = !wr && addr == 8'h08;
            exp_rdy = !is_val || ref_rdy || ref_cfg[2];
            rtag    = wr ? "R9" : (is_val ? (ref_cfg[2] ? "R8" : "R7") : "R10");
            check(rdy == exp_rdy, rtag, {31'b0, rdy}, {31'b0, exp_rdy});
            if (rdy && sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                if (!it.wr) begin
                    case (it.addr)
                        8'h00:   exp_d = {16'h0, ref_cfg};
                        8'h04:   exp_d = {31'b0, ref_rdy & ~ref_cfg[2]};
                        8'h08:   exp_d = ref_cfg[2] ? 32'h0 : {16'h0, ref_val};
                        default: exp_d = 32'h0;
                    endcase
                    check(rdata == exp_d, it.tag, rdata, exp_d);
                end
                -> done_ev;
            end
        end
    end

    task automatic xfer(input logic w, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d;
        sb_q.push_back('{w, a, tag});
        @(done_ev);
        @(posedge clk);
        #1 sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(rdy == 1'b0, "R1", {31'b0, rdy}, 32'h0);
        xfer(0, 8'h00, 0, "R1");           // config reset value
        xfer(0, 8'h04, 0, "R1");           // not yet valid
        xfer(0, 8'h08, 0, "R7");           // stalls until first value, R5 data
        xfer(0, 8'h04, 0, "R6");           // take cleared the flag
        idle(GEN + 4);
        xfer(0, 8'h04, 0, "R5");           // valid after the window
        xfer(0, 8'h08, 0, "R6");           // immediate read
        xfer(0, 8'h08, 0, "R7");           // back-to-back read stalls
        idle(GEN + 2);
        xfer(1, 8'h00, 32'hFFFF_1234, "R2"); // bit 2 set: power down
        xfer(0, 8'h00, 0, "R2");
        xfer(0, 8'h04, 0, "R4");
        xfer(0, 8'h08, 0, "R8");
        idle(60);
        xfer(0, 8'h04, 0, "R3");
        xfer(1, 8'h00, 32'h0000_0010, "R2"); // power up
        xfer(0, 8'h00, 0, "R2");
        xfer(0, 8'h08, 0, "R3");           // frozen state resumes, full window
        xfer(1, 8'h04, 32'hFFFF_FFFF, "R9");
        xfer(1, 8'h08, 32'hFFFF_FFFF, "R9");
        xfer(1, 8'h0C, 32'hFFFF_FFFF, "R9");
        xfer(1, 8'h02, 32'hFFFF_FFFF, "R9");
        xfer(0, 8'h00, 0, "R9");           // still 0x0010
        xfer(0, 8'h0C, 0, "R10");
        xfer(0, 8'h01, 0, "R10");
        xfer(0, 8'h80, 0, "R10");
        idle(GEN + 2);
        xfer(1, 8'h00, 32'h0000_0004, "R4"); // power down while valid
        xfer(0, 8'h04, 0, "R4");
        xfer(1, 8'h00, 32'h0000_0000, "R3");
        xfer(0, 8'h08, 0, "R5");
        idle(3);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule